// File: doc/BRIEF.md
# Compute-Instruction Decoder for an SRAM Port

This block sits between a processor's synchronous SRAM port and a memory array that can also compute on its own rows. A processor sends a compute instruction by making one ordinary store. The top bit of the store address marks the cycle as an instruction. The low twelve address bits name the row that receives the result. The stored data word holds the opcode, two twelve-bit operand fields and a pattern-select bit. Because the instruction travels as a plain store, the processor's instruction set does not change. Loads and stores without the flag go straight to the array in the same cycle.

For each accepted instruction the decoder unpacks the fields into registers. It then raises a one-cycle command strobe towards the compute engine. The most significant opcode bit picks the form. In two-operand form, the two fields are source rows. In multi-operand form, they are the address and mask that drive the row-pattern selector. A two-operand instruction with the pattern bit set is malformed. It is rejected and nothing is issued. While the engine works, the decoder holds its ready signal low, so the processor's next access stalls. Ready returns after the engine reports completion.

Top module: `imc_bus_decoder`

## Requirements
- R1: After reset, `bus_ready` is 1 and `cmd_valid` and `cmd_reject` are 0.
- R2: An accepted access with address bit 31 clear drives the array in the same cycle. The outputs are `mem_en`=1, `mem_we`=`bus_we`, `mem_addr`=`bus_addr[30:0]` and `mem_wdata`=`bus_wdata`. `bus_rdata` always equals `mem_rdata`.
- R3: An accepted write with address bit 31 set never enables the array. If the instruction is well formed, `cmd_valid` is 1 for exactly the next cycle. The registered fields are then: opcode = `bus_wdata[31:25]`, field A = `bus_wdata[24:13]`, field B = `bus_wdata[12:1]`, pattern bit = `bus_wdata[0]`, destination = `bus_addr[11:0]`.
- R4: `cmd_multi` copies opcode bit 6 (`bus_wdata[31]`). The value 1 marks the multi-operand form, in which A and B are the pattern address and mask. The value 0 marks the two-operand form, in which A and B are source rows.
- R5: An accepted read with address bit 31 set is an ordinary array read of row `bus_addr[11:0]`. The address is zero-extended onto `mem_addr`, with `mem_en`=1 and `mem_we`=0. No command follows.
- R6: A flagged write in two-operand form (`bus_wdata[31]`=0) with pattern bit `bus_wdata[0]`=1 gives `cmd_reject`=1 for the next cycle. It issues no command, does not enable the array and leaves `bus_ready` high.
- R7: From the cycle after a command is accepted, `bus_ready` is 0. It stays 0 up to and including the cycle in which `cmd_done` is 1, and returns to 1 in the next cycle. While `bus_ready` is 0, no access reaches the array and no instruction is decoded.
- R8: `cmd_done` while no command is running has no effect.
- R9: A multi-operand instruction is issued with either value of the pattern bit, and the bit is forwarded unchanged.
- R10: With `bus_valid`=0 nothing is accepted: `mem_en` stays 0 and neither `cmd_valid` nor `cmd_reject` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Processor access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Address; bit 31 is the instruction flag, bits 11:0 the row |
| bus_wdata | input | 32 | Write data or packed instruction |
| bus_ready | output | 1 | Access accepted when high together with bus_valid |
| bus_rdata | output | 32 | Read data returned to the processor |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 31 | Array address |
| mem_wdata | output | 32 | Array write data |
| mem_rdata | input | 32 | Array read data |
| cmd_valid | output | 1 | One-cycle command strobe to the compute engine |
| cmd_multi | output | 1 | 1 = multi-operand form |
| cmd_opcode | output | 7 | Operation code |
| cmd_field_a | output | 12 | Source row A or pattern address |
| cmd_field_b | output | 12 | Source row B or pattern mask |
| cmd_pattern | output | 1 | Pattern-select bit |
| cmd_dest | output | 12 | Result row |
| cmd_done | input | 1 | Compute engine has finished |
| cmd_reject | output | 1 | One-cycle pulse for a malformed instruction |

## Verification
The hardest situation to reach is a stall while the processor keeps its request asserted and the engine answers late. In that case the held access must neither reach the array nor be decoded twice. Once ready returns, the held access must be taken exactly once. The stimulus issues an instruction and keeps a flagged write, then an ordinary write, on the bus for several cycles with completion held back. It then raises completion and follows the held access through to acceptance. It also sends completion while idle, and sends a malformed instruction right after a stall ends.

// File: rtl/imc_bus_decoder.sv
module imc_bus_decoder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OP_W   = 7,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_valid,
  output logic              cmd_multi,
  output logic [OP_W-1:0]   cmd_opcode,
  output logic [ROW_W-1:0]  cmd_field_a,
  output logic [ROW_W-1:0]  cmd_field_b,
  output logic              cmd_pattern,
  output logic [ROW_W-1:0]  cmd_dest,
  input  logic              cmd_done,
  output logic              cmd_reject
);
  localparam int FLAG   = ADDR_W - 1;
  localparam int MEM_AW = ADDR_W - 1;
  localparam int OP_LSB = DATA_W - OP_W;
  localparam int A_LSB  = OP_LSB - ROW_W;
  localparam int B_LSB  = A_LSB - ROW_W;

  logic busy;
  logic take, smart, instr, multi, sel, bad, issue;

  assign bus_ready = !busy;
  assign take      = bus_valid && bus_ready;
  assign smart     = bus_addr[FLAG];
  assign instr     = take && bus_we && smart;
  assign multi     = bus_wdata[DATA_W-1];
  assign sel       = bus_wdata[0];
  assign bad       = instr && !multi && sel;
  assign issue     = instr && !bad;

  assign mem_en    = take && !(bus_we && smart);
  assign mem_we    = bus_we;
  assign mem_addr  = smart ? MEM_AW'(bus_addr[ROW_W-1:0]) : bus_addr[MEM_AW-1:0];
  assign mem_wdata = bus_wdata;
  assign bus_rdata = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_reject  <= 1'b0;
      cmd_multi   <= 1'b0;
      cmd_opcode  <= '0;
      cmd_field_a <= '0;
      cmd_field_b <= '0;
      cmd_pattern <= 1'b0;
      cmd_dest    <= '0;
    end else begin
      cmd_valid  <= issue;
      cmd_reject <= bad;
      if (busy && cmd_done) busy <= 1'b0;
      else if (issue)       busy <= 1'b1;
      if (issue) begin
        cmd_multi   <= multi;
        cmd_opcode  <= bus_wdata[DATA_W-1:OP_LSB];
        cmd_field_a <= bus_wdata[OP_LSB-1:A_LSB];
        cmd_field_b <= bus_wdata[A_LSB-1:B_LSB];
        cmd_pattern <= sel;
        cmd_dest    <= bus_addr[ROW_W-1:0];
      end
    end
  end
endmodule

// File: rtl/imc_bus_decoder_chk.sv
module imc_bus_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_valid,
  input logic bus_we,
  input logic flag,
  input logic op_multi,
  input logic sel_bit,
  input logic bus_ready,
  input logic mem_en,
  input logic mem_we,
  input logic cmd_valid,
  input logic cmd_reject,
  input logic cmd_done
);
  logic acc, good, bad;
  assign acc  = bus_valid && bus_ready;
  assign bad  = acc && bus_we && flag && !op_multi && sel_bit;
  assign good = acc && bus_we && flag && !bad;

  assert_issue_next_R3: assert property (@(posedge clk) disable iff (!rst_n) good |=> cmd_valid);
  assert_issue_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid);
  assert_no_array_instr_R3: assert property (@(posedge clk) disable iff (!rst_n) (acc && bus_we && flag) |-> !mem_en);
  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n) bad |=> (cmd_reject && !cmd_valid && bus_ready));
  assert_busy_after_issue_R7: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> !bus_ready);
  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n) !bus_ready |-> !mem_en);
  assert_stall_no_decode_R7: assert property (@(posedge clk) disable iff (!rst_n) !bus_ready |=> !cmd_valid && !cmd_reject);
  assert_flag_read_R5: assert property (@(posedge clk) disable iff (!rst_n) (acc && !bus_we && flag) |-> (mem_en && !mem_we));
  assert_idle_done_R8: assert property (@(posedge clk) disable iff (!rst_n) (bus_ready && cmd_done && !(bus_valid && bus_we && flag)) |=> bus_ready);
  assert_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n) !bus_valid |-> !mem_en);
  assert_no_req_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n) !bus_valid |=> (!cmd_valid && !cmd_reject));
endmodule

bind imc_bus_decoder imc_bus_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .flag(bus_addr[ADDR_W-1]), .op_multi(bus_wdata[DATA_W-1]), .sel_bit(bus_wdata[0]),
  .bus_ready(bus_ready), .mem_en(mem_en), .mem_we(mem_we),
  .cmd_valid(cmd_valid), .cmd_reject(cmd_reject), .cmd_done(cmd_done)
);

// File: tb/tb_imc_bus_decoder.sv
module tb_imc_bus_decoder;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, mem_rdata = 0;
  logic bus_ready, mem_en, mem_we, cmd_valid, cmd_multi, cmd_pattern, cmd_reject;
  logic cmd_done = 0;
  logic [31:0] bus_rdata, mem_wdata;
  logic [30:0] mem_addr;
  logic [6:0]  cmd_opcode;
  logic [11:0] cmd_field_a, cmd_field_b, cmd_dest;

  imc_bus_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
    .cmd_multi(cmd_multi), .cmd_opcode(cmd_opcode), .cmd_field_a(cmd_field_a),
    .cmd_field_b(cmd_field_b), .cmd_pattern(cmd_pattern), .cmd_dest(cmd_dest),
    .cmd_done(cmd_done), .cmd_reject(cmd_reject)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit m_busy = 0, m_cv = 0, m_rej = 0;
  logic [31:0] m_word = 0;
  logic [11:0] m_dest = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [6:0] op, input logic [11:0] a, input logic [11:0] b, input logic sp);
    return {op, a, b, sp};
  endfunction

  task automatic drive(input logic v, input logic we, input logic [31:0] ad, input logic [31:0] wd, input logic dn);
    bus_valid = v; bus_we = we; bus_addr = ad; bus_wdata = wd; cmd_done = dn;
    mem_rdata = ad ^ 32'h5A5A_0F0F;
  endtask

  task automatic step(input string tag);
    bit acc, instr, bad, en;
    logic [30:0] ea;
    #1;
    acc   = bus_valid && !m_busy;
    instr = acc && bus_we && bus_addr[31];
    bad   = instr && !bus_wdata[31] && bus_wdata[0];
    en    = acc && !(bus_we && bus_addr[31]);
    ea    = bus_addr[31] ? {19'd0, bus_addr[11:0]} : bus_addr[30:0];
    chk(tag, "bus_ready", {31'd0, bus_ready}, {31'd0, !m_busy});
    chk(tag, "mem_en", {31'd0, mem_en}, {31'd0, en});
    chk(tag, "bus_rdata", bus_rdata, mem_rdata);
    if (en) begin
      chk(tag, "mem_we", {31'd0, mem_we}, {31'd0, bus_we});
      chk(tag, "mem_addr", {1'b0, mem_addr}, {1'b0, ea});
      if (bus_we) chk(tag, "mem_wdata", mem_wdata, bus_wdata);
    end
    @(posedge clk);
    if (m_busy && cmd_done) m_busy = 0;
    else if (instr && !bad) m_busy = 1;
    m_cv  = instr && !bad;
    m_rej = bad;
    if (m_cv) begin m_word = bus_wdata; m_dest = bus_addr[11:0]; end
    #1;
    chk(tag, "cmd_valid", {31'd0, cmd_valid}, {31'd0, m_cv});
    chk(tag, "cmd_reject", {31'd0, cmd_reject}, {31'd0, m_rej});
    if (m_cv) begin
      chk(tag, "cmd_opcode", {25'd0, cmd_opcode}, {25'd0, m_word[31:25]});
      chk(tag, "cmd_field_a", {20'd0, cmd_field_a}, {20'd0, m_word[24:13]});
      chk(tag, "cmd_field_b", {20'd0, cmd_field_b}, {20'd0, m_word[12:1]});
      chk(tag, "cmd_pattern", {31'd0, cmd_pattern}, {31'd0, m_word[0]});
      chk(tag, "cmd_multi", {31'd0, cmd_multi}, {31'd0, m_word[31]});
      chk(tag, "cmd_dest", {20'd0, cmd_dest}, {20'd0, m_dest});
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1", "bus_ready", {31'd0, bus_ready}, 32'd1);
    chk("R1", "cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R1", "cmd_reject", {31'd0, cmd_reject}, 32'd0);

    drive(1, 1, 32'h0000_0ABC, 32'h1234_5678, 0); step("R2 write");
    drive(1, 0, 32'h7FFF_F001, 32'h0, 0);         step("R2 read");
    drive(1, 0, 32'h8000_0345, 32'h0, 0);         step("R5 flagged read");
    drive(0, 1, 32'h8000_0111, pack(7'h05, 12'h1, 12'h2, 0), 0); step("R10 idle");
    drive(1, 0, 32'h0000_0010, 32'h0, 1);         step("R8 done idle");
    drive(1, 1, 32'h0000_0020, 32'hDEAD_BEEF, 0); step("R8 after done");

    drive(1, 1, 32'h8000_07FF, pack(7'h05, 12'h123, 12'hABC, 0), 0); step("R3 two-op");
    drive(1, 1, 32'h8000_0001, pack(7'h06, 12'h111, 12'h222, 0), 0);
    for (int i = 0; i < 3; i++) step("R7 stall flagged");
    drive(1, 1, 32'h0000_0044, 32'hA5A5_A5A5, 0);
    for (int i = 0; i < 2; i++) step("R7 stall plain");
    drive(1, 1, 32'h0000_0044, 32'hA5A5_A5A5, 1); step("R7 done");
    drive(1, 1, 32'h0000_0044, 32'hA5A5_A5A5, 0); step("R7 resume");

    drive(1, 1, 32'h8000_0333, pack(7'h11, 12'h0F0, 12'h00F, 1), 0); step("R6 reject");
    drive(1, 0, 32'h0000_0333, 32'h0, 0); step("R6 ready kept");

    drive(1, 1, 32'h8000_0C0D, pack(7'h48, 12'h6A5, 12'hF0C, 1), 0); step("R4 R9 multi sp1");
    drive(0, 0, 32'h0, 32'h0, 1); step("R9 done");
    drive(1, 1, 32'h8000_0FFF, pack(7'h7F, 12'hFFF, 12'h000, 0), 0); step("R4 R9 multi sp0");
    drive(1, 0, 32'h8000_0FFF, 32'h0, 0); step("R7 held read");
    drive(1, 0, 32'h8000_0FFF, 32'h0, 1); step("R7 done read");
    drive(1, 1, 32'h8000_0001, pack(7'h02, 12'h001, 12'h002, 1), 0); step("R6 after stall");
    drive(0, 0, 32'h0, 32'h0, 0); step("R10 quiet");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule